// File: doc/BRIEF.md
# Lens Actuator Ramp Power Sequencer

This block drives a voice-coil lens actuator through its register interface. It owns the power-up and power-down choreography. On a power-up request it clears the actuator's control register and waits out the operating delay. It then enables ringing control and applies the damping mode, clock prescale and vibration timing to the configuration registers. Finally it brings the lens up to the stored target in coarse steps. On a power-down request it walks the lens back to zero in the same coarse steps, sets the power-down bit and waits the operating delay again. The lens is never jumped.

Every register access leaves through a valid/ready command port as an address, a one- or two-byte write payload and a read/write flag. The response (acknowledge or error, plus read data) comes back on a separate response strobe. After each position write the block pulses a request to an external settle timer and holds until that timer reports completion. The settle timer derives the per-step delay from the damping configuration. Position updates that arrive while the actuator is powered and no sequence is running go straight to the actuator as a single position write.

Top module: `lens_ramp_seq`

## Requirements
- R1: After reset, cmd_valid, step_go, busy, powered and error are all 0.
- R2: Once cmd_valid is raised it stays high, with address, write flag, length and payload unchanged, until the cycle cmd_ready is high. Only one transaction is outstanding at a time: the next command starts only after rsp_valid answers the previous one.
- R3: A power-up request while unpowered first writes 0x00 to control register 0x02. After the acknowledge it waits at least OPR_CYC cycles. It then writes 0x02 (bit 1 = ringing enable, bit 0 = power-down) to register 0x02.
- R4: Next it reads register 0x06 and writes it back with bits 7:5 replaced by cfg_mode and bits 4:0 kept from the read data.
- R5: When cfg_presc is not 1, it reads register 0x06 again and writes it back with bits 2:0 replaced by cfg_presc and bits 7:3 kept. When cfg_presc is 1, neither access is made.
- R6: Register 0x07 is written with {2'b00, cfg_time} only when cfg_time is not 0x20.
- R7: Every position write is a two-byte write (cmd_two = 1) to address 0x03. Payload bits 15:8 hold the upper position bits zero-extended (the byte for 0x03) and bits 7:0 hold the lower eight bits (the byte for 0x04).
- R8: The power-up ramp writes positions target mod 16, then +16 each step, ending exactly at the target. After each write acknowledge, step_go pulses once and the next access waits for step_done.
- R9: A power-down request while powered writes the target rounded down to a multiple of 16, then descends by 16 through 0 with one step_go and step_done wait per write. It then writes 0x01 to register 0x02, holds busy for at least OPR_CYC more cycles, and clears powered.
- R10: busy is high for the whole of either sequence. A pos_wr during a sequence is discarded and leaves the stored target unchanged.
- R11: With no sequence running, pos_wr stores pos_data as the target. When powered, it also issues exactly one position write without raising busy. When unpowered, it issues no command.
- R12: An error response ends the sequence at once: error goes to 1, busy drops and no further command is issued. The next accepted power request clears error.
- R13: A power-up request while powered, or a power-down request while unpowered, issues no command and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up_req | input | 1 | Request power-up sequence |
| pwr_dn_req | input | 1 | Request power-down sequence |
| pos_wr | input | 1 | Position update strobe |
| pos_data | input | POS_W | New lens target position |
| cfg_mode | input | 3 | Damping mode code for register 0x06 bits 7:5 |
| cfg_presc | input | 3 | Prescale code for register 0x06 bits 2:0 |
| cfg_time | input | 6 | Vibration timing for register 0x07 |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by the link |
| cmd_write | output | 1 | 1 = write, 0 = one-byte read |
| cmd_two | output | 1 | 1 = two-byte write |
| cmd_addr | output | 8 | Register address |
| cmd_wdata | output | 16 | Write payload (one-byte writes use bits 7:0) |
| rsp_valid | input | 1 | Response strobe for the outstanding command |
| rsp_err | input | 1 | Response reports failure |
| rsp_rdata | input | 8 | Read data with the response |
| step_go | output | 1 | Pulse: start one settle delay |
| step_done | input | 1 | Pulse: settle delay finished |
| busy | output | 1 | A power sequence is running |
| powered | output | 1 | Actuator powered and configured |
| error | output | 1 | Last sequence or update aborted |

## Verification
The assertions watch the cycle-level rules on every cycle. They check that a command holds steady while stalled and that a position payload never has bits set above the position width. They also check that step_go occurs only inside a sequence, that the only command issued with busy low is a direct position write, and that error never rises while busy is high. Only the bench's scenarios can show the order and content of a whole sequence. That covers the read-modify-write values, which optional writes are skipped under which settings, the exact ramp position lists, the length of both operating delays, that a rejected update leaves the target unchanged, and that nothing is sent after an abort.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

   localparam logic [7:0] ADDR_CTRL = 8'h02;
   localparam logic [7:0] ADDR_POS  = 8'h03;
   localparam logic [7:0] ADDR_CFG  = 8'h06;
   localparam logic [7:0] ADDR_TIME = 8'h07;

   localparam int CTRL_PD_BIT   = 0;
   localparam int CTRL_RING_BIT = 1;

   localparam logic [2:0] PRESC_DEF = 3'd1;
   localparam logic [5:0] TIME_DEF  = 6'h20;

   typedef struct packed {
      logic        wr;
      logic        two;
      logic [7:0]  addr;
      logic [15:0] data;
   } xact_t;

   typedef enum logic [3:0] {
      S_IDLE, S_CLR, S_TOPR_UP, S_RING, S_MODE_RD, S_MODE_WR,
      S_PSC_RD, S_PSC_WR, S_TIME_WR, S_UP_WR, S_UP_SETTLE,
      S_DN_WR, S_DN_SETTLE, S_PDOWN, S_TOPR_DN, S_DIRECT
   } seq_t;

endpackage

// File: rtl/lrs_wait_timer.sv
module lrs_wait_timer #(
   parameter int CYC = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CW = $clog2(CYC + 1);

   generate
      if (CYC < 2) begin : g_bad_cyc
         $error("lrs_wait_timer: CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (start) begin
         cnt <= CW'(CYC);
         run <= 1'b1;
      end else if (run) begin
         cnt <= cnt - 1'b1;
         if (cnt == CW'(1)) run <= 1'b0;
      end
   end

   assign done = run && (cnt == CW'(1));

endmodule

// File: rtl/lrs_xact_port.sv
module lrs_xact_port
   import lrs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req,
   input  xact_t req_x,
   output logic  cmd_valid,
   input  logic  cmd_ready,
   output xact_t cmd_x,
   input  logic  rsp_valid,
   input  logic  rsp_err,
   output logic  done,
   output logic  done_err
);
   typedef enum logic [1:0] {P_IDLE, P_ISSUE, P_WAIT} pst_t;
   pst_t pst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pst   <= P_IDLE;
         cmd_x <= '0;
      end else begin
         case (pst)
            P_IDLE:  if (req) begin
                        cmd_x <= req_x;
                        pst   <= P_ISSUE;
                     end
            P_ISSUE: if (cmd_ready) pst <= P_WAIT;
            P_WAIT:  if (rsp_valid) pst <= P_IDLE;
            default: pst <= P_IDLE;
         endcase
      end
   end

   assign cmd_valid = (pst == P_ISSUE);
   assign done      = (pst == P_WAIT) && rsp_valid;
   assign done_err  = done && rsp_err;

   // R2: a stalled command keeps every field
   a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_x));

endmodule

// File: rtl/lens_ramp_seq.sv
module lens_ramp_seq
   import lrs_pkg::*;
#(
   parameter int POS_W     = 10,
   parameter int STEP_LOG2 = 4,
   parameter int OPR_CYC   = 50000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_up_req,
   input  logic             pwr_dn_req,
   input  logic             pos_wr,
   input  logic [POS_W-1:0] pos_data,
   input  logic [2:0]       cfg_mode,
   input  logic [2:0]       cfg_presc,
   input  logic [5:0]       cfg_time,
   output logic             cmd_valid,
   input  logic             cmd_ready,
   output logic             cmd_write,
   output logic             cmd_two,
   output logic [7:0]       cmd_addr,
   output logic [15:0]      cmd_wdata,
   input  logic             rsp_valid,
   input  logic             rsp_err,
   input  logic [7:0]       rsp_rdata,
   output logic             step_go,
   input  logic             step_done,
   output logic             busy,
   output logic             powered,
   output logic             error
);
   localparam int               STEP      = 1 << STEP_LOG2;
   localparam logic [POS_W-1:0] STEP_MASK = POS_W'(STEP - 1);
   localparam logic [POS_W-1:0] STEP_INC  = POS_W'(STEP);

   generate
      if (POS_W < 9 || POS_W > 16) begin : g_bad_pos_w
         $error("lens_ramp_seq: POS_W must be 9..16");
      end
      if (STEP_LOG2 < 0 || STEP_LOG2 >= POS_W) begin : g_bad_step
         $error("lens_ramp_seq: STEP_LOG2 out of range");
      end
   endgenerate

   seq_t             st;
   logic [POS_W-1:0] tgt, cur;
   logic [7:0]       rbyte;
   logic             req;
   xact_t            req_x, cmd_x;
   logic             done, done_err, t_start, t_done;

   always_comb begin
      req   = 1'b1;
      req_x = '{wr: 1'b1, two: 1'b0, addr: ADDR_CTRL, data: 16'h0000};
      case (st)
         S_CLR:     req_x.data = 16'h0000;
         S_RING:    req_x.data = 16'(1 << CTRL_RING_BIT);
         S_PDOWN:   req_x.data = 16'(1 << CTRL_PD_BIT);
         S_MODE_RD, S_PSC_RD: begin
            req_x.wr   = 1'b0;
            req_x.addr = ADDR_CFG;
         end
         S_MODE_WR: begin
            req_x.addr = ADDR_CFG;
            req_x.data = {8'h00, cfg_mode, rbyte[4:0]};
         end
         S_PSC_WR: begin
            req_x.addr = ADDR_CFG;
            req_x.data = {8'h00, rbyte[7:3], cfg_presc};
         end
         S_TIME_WR: begin
            req_x.addr = ADDR_TIME;
            req_x.data = {10'h000, cfg_time};
         end
         S_UP_WR, S_DN_WR, S_DIRECT: begin
            req_x.two  = 1'b1;
            req_x.addr = ADDR_POS;
            req_x.data = 16'(cur);
         end
         default:   req = 1'b0;
      endcase
   end

   lrs_xact_port u_port (
      .clk, .rst_n, .req, .req_x, .cmd_valid, .cmd_ready, .cmd_x,
      .rsp_valid, .rsp_err, .done, .done_err
   );

   assign t_start = done && !done_err && (st == S_CLR || st == S_PDOWN);

   lrs_wait_timer #(.CYC(OPR_CYC)) u_opr (
      .clk, .rst_n, .start(t_start), .done(t_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         tgt     <= '0;
         cur     <= '0;
         rbyte   <= '0;
         powered <= 1'b0;
         error   <= 1'b0;
         step_go <= 1'b0;
      end else begin
         step_go <= 1'b0;
         if (done_err) begin
            error <= 1'b1;
            st    <= S_IDLE;
         end else begin
            case (st)
               S_IDLE: begin
                  if (pwr_up_req && !powered) begin
                     error <= 1'b0;
                     st    <= S_CLR;
                  end else if (pwr_dn_req && powered) begin
                     error <= 1'b0;
                     cur   <= tgt & ~STEP_MASK;
                     st    <= S_DN_WR;
                  end else if (pos_wr) begin
                     tgt <= pos_data;
                     if (powered) begin
                        cur <= pos_data;
                        st  <= S_DIRECT;
                     end
                  end
               end
               S_CLR:     if (done) st <= S_TOPR_UP;
               S_TOPR_UP: if (t_done) st <= S_RING;
               S_RING:    if (done) st <= S_MODE_RD;
               S_MODE_RD: if (done) begin
                  rbyte <= rsp_rdata;
                  st    <= S_MODE_WR;
               end
               S_MODE_WR, S_PSC_WR: if (done) begin
                  if (st == S_MODE_WR && cfg_presc != PRESC_DEF) begin
                     st <= S_PSC_RD;
                  end else if (cfg_time != TIME_DEF) begin
                     st <= S_TIME_WR;
                  end else begin
                     cur <= tgt & STEP_MASK;
                     st  <= S_UP_WR;
                  end
               end
               S_PSC_RD:  if (done) begin
                  rbyte <= rsp_rdata;
                  st    <= S_PSC_WR;
               end
               S_TIME_WR: if (done) begin
                  cur <= tgt & STEP_MASK;
                  st  <= S_UP_WR;
               end
               S_UP_WR, S_DN_WR: if (done) begin
                  step_go <= 1'b1;
                  st      <= (st == S_UP_WR) ? S_UP_SETTLE : S_DN_SETTLE;
               end
               S_UP_SETTLE: if (step_done) begin
                  if (cur == tgt) begin
                     powered <= 1'b1;
                     st      <= S_IDLE;
                  end else begin
                     cur <= cur + STEP_INC;
                     st  <= S_UP_WR;
                  end
               end
               S_DN_SETTLE: if (step_done) begin
                  if (cur == '0) begin
                     st <= S_PDOWN;
                  end else begin
                     cur <= cur - STEP_INC;
                     st  <= S_DN_WR;
                  end
               end
               S_PDOWN:   if (done) st <= S_TOPR_DN;
               S_TOPR_DN: if (t_done) begin
                  powered <= 1'b0;
                  st      <= S_IDLE;
               end
               S_DIRECT:  if (done) st <= S_IDLE;
               default:   st <= S_IDLE;
            endcase
         end
      end
   end

   assign busy      = (st != S_IDLE) && (st != S_DIRECT);
   assign cmd_write = cmd_x.wr;
   assign cmd_two   = cmd_x.two;
   assign cmd_addr  = cmd_x.addr;
   assign cmd_wdata = cmd_x.data;

   // R7: position payload never carries bits above the position width
   a_r7_pos_payload: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_addr == ADDR_POS |-> cmd_two && cmd_write && ((cmd_wdata >> POS_W) == 16'h0000));

   // R8: settle requests only happen inside a sequence
   a_r8_step_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
      step_go |-> busy);

   // R11: outside a sequence the only command is a position write
   a_r11_direct_only: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !busy |-> cmd_addr == ADDR_POS && cmd_two);

   // R12: an abort leaves the block idle
   a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> !busy);

endmodule

// File: tb/lens_ramp_seq_bench.sv
`timescale 1ns/1ps
module lens_ramp_seq_bench;
   localparam int TOPR = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_up_req = 1'b0, pwr_dn_req = 1'b0, pos_wr = 1'b0;
   logic [9:0] pos_data = '0;
   logic [2:0] cfg_mode = '0, cfg_presc = 3'd1;
   logic [5:0] cfg_time = 6'h20;
   logic       cmd_valid, cmd_write, cmd_two;
   logic       cmd_ready = 1'b0;
   logic [7:0] cmd_addr;
   logic [15:0] cmd_wdata;
   logic       rsp_valid = 1'b0, rsp_err = 1'b0;
   logic [7:0] rsp_rdata = '0;
   logic       step_go, step_done = 1'b0;
   logic       busy, powered, error;

   always #10 clk = ~clk;

   lens_ramp_seq #(.POS_W(10), .STEP_LOG2(4), .OPR_CYC(TOPR)) u_lens_ramp_seq (
      .clk, .rst_n, .pwr_up_req, .pwr_dn_req, .pos_wr, .pos_data,
      .cfg_mode, .cfg_presc, .cfg_time, .cmd_valid, .cmd_ready, .cmd_write,
      .cmd_two, .cmd_addr, .cmd_wdata, .rsp_valid, .rsp_err, .rsp_rdata,
      .step_go, .step_done, .busy, .powered, .error
   );

   int errors = 0, checks = 0, cyc = 0;
   logic [25:0] log_q [0:1023];
   int          hs_cyc [0:1023];
   int          log_n = 0, step_n = 0, nack_at = -1;
   logic [25:0] exp_q [0:255];
   int          exp_n;
   logic [7:0]  mreg [0:7];

   function automatic logic [25:0] pk(logic w, logic two, logic [7:0] a, logic [15:0] d);
      return {w, two, a, d};
   endfunction

   task automatic chk(logic ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   // link responder and settle timer model
   initial begin
      int rcnt = 0, scnt = 0;
      logic perr = 1'b0;
      logic [7:0] prd = '0;
      for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
      mreg[6] = 8'h5A;
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0;
         step_done = 1'b0;
         if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) begin
               rsp_valid = 1'b1;
               rsp_err   = perr;
               rsp_rdata = prd;
            end
         end
         if (scnt > 0) begin
            scnt--;
            if (scnt == 0) step_done = 1'b1;
         end
         if (step_go) begin
            scnt = 3;
            step_n++;
         end
         cmd_ready = (cyc % 3) != 1;
         if (cmd_valid && cmd_ready) begin
            log_q[log_n]  = pk(cmd_write, cmd_two, cmd_addr, cmd_wdata);
            hs_cyc[log_n] = cyc;
            prd  = mreg[cmd_addr[2:0]];
            perr = (log_n == nack_at);
            if (cmd_write) begin
               if (cmd_two) begin
                  mreg[cmd_addr[2:0]]       = cmd_wdata[15:8];
                  mreg[cmd_addr[2:0] + 3'd1] = cmd_wdata[7:0];
               end else begin
                  mreg[cmd_addr[2:0]] = cmd_wdata[7:0];
               end
            end
            log_n++;
            rcnt = 2;
         end
      end
   end

   task automatic pulse(ref logic sig);
      @(negedge clk);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      repeat (3) @(negedge clk);
      while (busy && n < 50000) begin
         @(negedge clk);
         n++;
      end
      chk(!busy, "R10 sequence finished", busy, 0);
   endtask

   task automatic compare(int base, string req);
      chk(log_n - base == exp_n, req, log_n - base, exp_n);
      for (int i = 0; i < exp_n; i++)
         chk(log_q[base + i] == exp_q[i], req, log_q[base + i], exp_q[i]);
   endtask

   task automatic do_up(int tg, int md, int ps, int tm);
      int base, s0, nst;
      logic [7:0] r6;
      cfg_mode = 3'(md); cfg_presc = 3'(ps); cfg_time = 6'(tm);
      base = log_n;
      @(negedge clk); pos_data = 10'(tg); pos_wr = 1'b1;
      @(negedge clk); pos_wr = 1'b0;
      repeat (8) @(negedge clk);
      chk(log_n == base, "R11 unpowered update sends nothing", log_n - base, 0);
      exp_n = 0;
      exp_q[exp_n++] = pk(1, 0, 8'h02, 16'h0000);
      exp_q[exp_n++] = pk(1, 0, 8'h02, 16'h0002);
      exp_q[exp_n++] = pk(0, 0, 8'h06, 16'h0000);
      r6 = {3'(md), mreg[6][4:0]};
      exp_q[exp_n++] = pk(1, 0, 8'h06, {8'h00, r6});
      if (ps != 1) begin
         exp_q[exp_n++] = pk(0, 0, 8'h06, 16'h0000);
         exp_q[exp_n++] = pk(1, 0, 8'h06, {8'h00, r6[7:3], 3'(ps)});
      end
      if (tm != 'h20) exp_q[exp_n++] = pk(1, 0, 8'h07, 16'(tm));
      nst = 0;
      for (int v = tg % 16; v <= tg; v += 16) begin
         exp_q[exp_n++] = pk(1, 1, 8'h03, {6'b0, 10'(v)});
         nst++;
      end
      s0 = step_n;
      pulse(pwr_up_req);
      repeat (3) @(negedge clk);
      chk(busy, "R10 busy during power-up", busy, 1);
      pos_data = 10'd999;
      pulse(pos_wr);
      wait_idle();
      compare(base, "R3 R4 R5 R6 R7 R8 power-up sequence");
      chk(hs_cyc[base + 1] - hs_cyc[base] >= TOPR, "R3 operating delay",
          hs_cyc[base + 1] - hs_cyc[base], TOPR);
      chk(step_n - s0 == nst, "R8 settle pulses", step_n - s0, nst);
      chk(powered && !error, "R8 powered after ramp", {powered, error}, 2);
   endtask

   task automatic do_dn(int tg);
      int base, s0, nst, idle_cyc;
      base = log_n;
      exp_n = 0; nst = 0;
      for (int v = tg - (tg % 16); v >= 0; v -= 16) begin
         exp_q[exp_n++] = pk(1, 1, 8'h03, {6'b0, 10'(v)});
         nst++;
      end
      exp_q[exp_n++] = pk(1, 0, 8'h02, 16'h0001);
      s0 = step_n;
      pulse(pwr_dn_req);
      wait_idle();
      idle_cyc = cyc;
      compare(base, "R9 R10 power-down sequence");
      chk(step_n - s0 == nst, "R9 settle pulses", step_n - s0, nst);
      chk(idle_cyc - hs_cyc[log_n - 1] >= TOPR, "R9 final delay",
          idle_cyc - hs_cyc[log_n - 1], TOPR);
      chk(!powered, "R9 unpowered at end", powered, 0);
   endtask

   initial begin
      automatic int tgts[6] = '{0, 15, 16, 37, 1023, 530};
      int base;
      #1;
      chk(!cmd_valid && !step_go && !busy && !powered && !error, "R1 reset state",
          {cmd_valid, step_go, busy, powered, error}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!cmd_valid && !busy && !powered && !error, "R1 after release",
          {cmd_valid, busy, powered, error}, 0);

      base = log_n;
      pulse(pwr_dn_req);
      repeat (10) @(negedge clk);
      chk(log_n == base && !busy, "R13 power-down while unpowered", log_n - base, 0);

      for (int i = 0; i < 6; i++) begin
         do_up(tgts[i], (i * 3 + 1) % 8, (i % 3 == 0) ? 1 : i % 6,
               (i % 2) ? 'h20 : i * 7);
         if (i == 1) begin
            base = log_n;
            pulse(pwr_up_req);
            repeat (10) @(negedge clk);
            chk(log_n == base && !busy, "R13 power-up while powered", log_n - base, 0);
         end
         if (i == 2) begin
            base = log_n;
            @(negedge clk); pos_data = 10'd300; pos_wr = 1'b1;
            @(negedge clk); pos_wr = 1'b0;
            chk(!busy, "R11 direct update not busy", busy, 0);
            repeat (15) @(negedge clk);
            exp_n = 1;
            exp_q[0] = pk(1, 1, 8'h03, {6'b0, 10'd300});
            compare(base, "R11 R7 direct update");
            do_dn(300);
         end else begin
            do_dn(tgts[i]);
         end
      end

      base = log_n;
      nack_at = base + 3;
      pulse(pwr_up_req);
      wait_idle();
      chk(error, "R12 error flag", error, 1);
      chk(log_n == base + 4, "R12 no write after abort", log_n - base, 4);
      repeat (30) @(negedge clk);
      chk(log_n == base + 4 && !powered, "R12 stays quiet", log_n - base, 4);
      nack_at = -1;
      do_up(40, 6, 1, 'h20);
      chk(!error, "R12 error cleared by new request", error, 0);
      do_dn(40);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule